// File: doc/BRIEF.md
# Threshold-Flagged Packet Sink FIFO

This block is the receiving end of a streaming write link. An upstream master pushes one word on every cycle in which it raises its write enable. Each word carries a data field and two framing marks, one for the first word of a packet and one for the last. The block stores the words in arrival order. A local reader takes them out through a first-word fall-through pop port, where the head word is already on the outputs before it is popped.

The block does not use a ready/stall handshake. It reports through a registered room flag whether at least `THRESH` entries are free. A source that sees the flag high may start a burst. After the flag drops, the source may go on writing, but only up to the space that is really left. A source may also go idle at any time, whatever the flag says.

The block takes every write that arrives while it is not full. A write that arrives while it is full is dropped, and a sticky overflow bit records the protocol breach. An asynchronous active-low reset is synchronised inside the block before it reaches the state registers, so the block needs two clock edges after reset release before it accepts traffic.

Top module: `pkt_sink_fifo`

## Requirements
- R1: After reset, `rd_empty` is 1, `space_ok` is 1 and `overflow` is 0. A new reset clears a set `overflow` bit.
- R2: Every `wr_en` cycle in which the FIFO is not full stores `wr_data`, `wr_sop` and `wr_eop` as one word. Words leave in the order they were written.
- R3: A `wr_en` cycle while the FIFO holds `DEPTH` words stores nothing and leaves the stored words unchanged. It sets `overflow`, which stays 1 until reset.
- R4: In each cycle, `space_ok` is 1 exactly when `DEPTH` minus the occupancy held during the previous cycle is at least `THRESH`. The flag therefore lags occupancy by one cycle.
- R5: While `rd_empty` is 0, `rd_data`, `rd_sop` and `rd_eop` show the oldest stored word before any pop. They change only when that word is popped.
- R6: `rd_empty` is 1 exactly when no word is stored. An `rd_pop` while empty has no effect.
- R7: A cycle with both `wr_en` and `rd_pop`, on a FIFO that is neither empty nor full, removes the head word, stores the new word and leaves the occupancy unchanged.
- R8: Writes go on being accepted after `space_ok` falls, until `DEPTH` words are held.
- R9: A cycle with both `wr_en` and `rd_pop` on a full FIFO pops the head word, drops the written word and sets `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Source writes a word this cycle |
| wr_data | input | DATA_W | Data field of the written word |
| wr_sop | input | 1 | Written word starts a packet |
| wr_eop | input | 1 | Written word ends a packet |
| space_ok | output | 1 | At least THRESH entries were free last cycle |
| overflow | output | 1 | Sticky: a write arrived while the FIFO was full |
| rd_pop | input | 1 | Reader removes the head word |
| rd_empty | output | 1 | No word is stored |
| rd_data | output | DATA_W | Data field of the head word |
| rd_sop | output | 1 | Start mark of the head word |
| rd_eop | output | 1 | End mark of the head word |

## Verification
The assertions assume that, after `rst_n` rises, the source keeps `wr_en` low for the two cycles in which the internal reset is still held. Without that, a write into an empty FIFO would seem to vanish. The room-flag property assumes `THRESH` is no larger than `DEPTH`. The stimulus drives all inputs low during the whole reset window plus three cycles, and uses only the default parameters, which meet that bound. Writes into a full FIFO are driven on purpose to exercise the overflow path, because the assertions do not rule them out.

// File: rtl/psf_pkg.sv
package psf_pkg;

  typedef struct packed {
    logic first;
    logic last;
  } psf_mark_t;

  // Room test used by the flag register: free entries against the threshold.
  function automatic logic psf_room_ok(input int unsigned free_cnt,
                                       input int unsigned thresh);
    return free_cnt >= thresh;
  endfunction

endpackage

// File: rtl/psf_rst_sync.sv
module psf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/psf_ptr_ctrl.sv
module psf_ptr_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          wr_go,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] occ,
  output logic          empty,
  output logic          ovf
);
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] occ_q, occ_d;
  logic          ovf_q, ovf_d;
  logic          full, rd_go;

  always_comb begin
    full   = (occ_q == CW'(DEPTH));
    empty  = (occ_q == '0);
    wr_go  = wr_req & ~full;
    rd_go  = rd_req & ~empty;
    wptr_d = wr_go ? wptr_q + AW'(1) : wptr_q;
    rptr_d = rd_go ? rptr_q + AW'(1) : rptr_q;
    unique case ({wr_go, rd_go})
      2'b10:   occ_d = occ_q + CW'(1);
      2'b01:   occ_d = occ_q - CW'(1);
      default: occ_d = occ_q;
    endcase
    ovf_d = ovf_q | (wr_req & full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      occ_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      occ_q  <= occ_d;
      ovf_q  <= ovf_d;
    end
  end

  assign wr_addr = wptr_q;
  assign rd_addr = rptr_q;
  assign occ     = occ_q;
  assign ovf     = ovf_q;
endmodule

// File: rtl/psf_store.sv
module psf_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int WW = DATA_W + 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wword,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rword
);
  logic [WW-1:0] ent_rd [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [WW-1:0] ent_q;
    logic          ent_en;

    assign ent_en = we && (waddr == AW'(i));

    always_ff @(posedge clk) begin
      if (ent_en) ent_q <= wword;
    end

    assign ent_rd[i] = ent_q;
  end

  assign rword = ent_rd[raddr];
endmodule

// File: rtl/psf_room_flag.sv
module psf_room_flag
  import psf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int THRESH = 4,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] occ,
  output logic          space_ok
);
  logic [CW-1:0] free_cnt;
  logic          ok_d, ok_q;

  always_comb begin
    free_cnt = CW'(DEPTH) - occ;
    ok_d     = psf_room_ok(int'(free_cnt), THRESH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_q <= 1'b1;
    else        ok_q <= ok_d;
  end

  assign space_ok = ok_q;
endmodule

// File: rtl/pkt_sink_fifo.sv
module pkt_sink_fifo
  import psf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int THRESH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_sop,
  input  logic              wr_eop,
  output logic              space_ok,
  output logic              overflow,
  input  logic              rd_pop,
  output logic              rd_empty,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_sop,
  output logic              rd_eop
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int WW = DATA_W + 2;

  logic          srst_n;
  logic          wr_go;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [CW-1:0] occ;
  logic [WW-1:0] in_word, out_word;
  psf_mark_t     in_mark, out_mark;

  psf_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  psf_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_req  (wr_en),
    .rd_req  (rd_pop),
    .wr_go   (wr_go),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .occ     (occ),
    .empty   (rd_empty),
    .ovf     (overflow)
  );

  always_comb begin
    in_mark.first = wr_sop;
    in_mark.last  = wr_eop;
    in_word       = {in_mark, wr_data};
  end

  psf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (wr_go),
    .waddr (wr_addr),
    .wword (in_word),
    .raddr (rd_addr),
    .rword (out_word)
  );

  psf_room_flag #(.DEPTH(DEPTH), .THRESH(THRESH)) u_flag (
    .clk      (clk),
    .rst_n    (srst_n),
    .occ      (occ),
    .space_ok (space_ok)
  );

  always_comb begin
    out_mark = psf_mark_t'(out_word[WW-1 -: 2]);
    rd_data  = out_word[DATA_W-1:0];
    rd_sop   = out_mark.first;
    rd_eop   = out_mark.last;
  end
endmodule

// File: rtl/psf_checker.sv
module psf_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_pop,
  input logic              rd_empty,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_sop,
  input logic              rd_eop,
  input logic              space_ok,
  input logic              overflow
);
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_empty && wr_en |=> !rd_empty);

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_room_after_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_empty |=> space_ok);

  assert_head_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_empty && !rd_pop |=> !rd_empty && $stable(rd_data) && $stable(rd_sop) && $stable(rd_eop));

  assert_idle_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_empty && !wr_en |=> rd_empty);
endmodule

bind pkt_sink_fifo psf_checker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .rd_pop   (rd_pop),
  .rd_empty (rd_empty),
  .rd_data  (rd_data),
  .rd_sop   (rd_sop),
  .rd_eop   (rd_eop),
  .space_ok (space_ok),
  .overflow (overflow)
);

// File: tb/tb_pkt_sink_fifo.sv
`timescale 1ns/1ps
module tb_pkt_sink_fifo;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int THRESH = 4;

  logic clk = 1'b0;
  logic rst_n, wr_en, wr_sop, wr_eop, rd_pop;
  logic [DW-1:0] wr_data, rd_data;
  logic space_ok, overflow, rd_empty, rd_sop, rd_eop;

  int tests = 0, fails = 0;
  logic [DW+1:0] q[$];
  logic exp_ovf;

  always #2.5 clk = ~clk;

  pkt_sink_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .THRESH(THRESH)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_sop(wr_sop),
    .wr_eop(wr_eop), .space_ok(space_ok), .overflow(overflow), .rd_pop(rd_pop),
    .rd_empty(rd_empty), .rd_data(rd_data), .rd_sop(rd_sop), .rd_eop(rd_eop));

  // Stimulus: {wr, pop, sop, eop, data}
  localparam logic [19:0] VEC [0:19] = '{
    20'hA_1001, 20'h8_1002, 20'h9_1003, 20'h4_0000, 20'hE_2001,
    20'h8_2002, 20'h8_2003, 20'h9_2004, 20'hC_3005, 20'h4_0000,
    20'h4_0000, 20'hB_4001, 20'h0_0000, 20'h4_0000, 20'h4_0000,
    20'h4_0000, 20'h4_0000, 20'h4_0000, 20'hC_5001, 20'h4_0000};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 0; rd_pop = 0; wr_sop = 0; wr_eop = 0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    q.delete();
    exp_ovf = 1'b0;
  endtask

  task automatic step(input logic w, input logic p, input logic s, input logic e, input logic [DW-1:0] d);
    int occ_b;
    logic exp_space;
    wr_en = w; rd_pop = p; wr_sop = s; wr_eop = e; wr_data = d;
    @(posedge clk);
    occ_b = q.size();
    exp_space = (DEPTH - occ_b) >= THRESH;
    if (w && occ_b == DEPTH) exp_ovf = 1'b1;
    if (p && occ_b > 0) void'(q.pop_front());
    if (w && occ_b < DEPTH) q.push_back({s, e, d});
    @(negedge clk);
    wr_en = 0; rd_pop = 0;
    chk(rd_empty == (q.size() == 0), "R6 empty", 32'(rd_empty), 32'(q.size() == 0));
    chk(space_ok == exp_space, "R4 space_ok", 32'(space_ok), 32'(exp_space));
    chk(overflow == exp_ovf, "R3 overflow", 32'(overflow), 32'(exp_ovf));
    if (q.size() > 0)
      chk({rd_sop, rd_eop, rd_data} == q[0], "R5 head word", 32'({rd_sop, rd_eop, rd_data}), 32'(q[0]));
  endtask

  task automatic drain(output int n);
    n = 0;
    for (int k = 0; k < DEPTH + 2 && !rd_empty; k++) begin
      chk({rd_sop, rd_eop, rd_data} == q[0], "R2 order", 32'({rd_sop, rd_eop, rd_data}), 32'(q[0]));
      step(0, 1, 0, 0, '0);
      n++;
    end
  endtask

  task automatic fill(input int cnt, input logic [DW-1:0] base);
    for (int k = 0; k < cnt; k++)
      step(1, 0, k == 0, k == cnt - 1, base + DW'(k));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int n;
    do_reset();
    // R1: reset state
    chk(rd_empty == 1'b1, "R1 empty", 32'(rd_empty), 1);
    chk(space_ok == 1'b1, "R1 space_ok", 32'(space_ok), 1);
    chk(overflow == 1'b0, "R1 overflow", 32'(overflow), 0);

    for (int i = 0; i < 20; i++)
      step(VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15:0]);

    // R4: threshold edge with one-cycle lag
    do_reset();
    fill(DEPTH - THRESH, 16'h6000);
    chk(space_ok == 1'b1, "R4 at threshold", 32'(space_ok), 1);
    step(1, 0, 0, 0, 16'h6FFF);
    chk(space_ok == 1'b1, "R4 lag", 32'(space_ok), 1);
    step(0, 0, 0, 0, '0);
    chk(space_ok == 1'b0, "R4 below threshold", 32'(space_ok), 0);

    // R8 / R3: write past flag drop to full, then one more
    do_reset();
    fill(DEPTH, 16'h7000);
    chk(space_ok == 1'b0 && !rd_empty, "R8 full with flag low", 32'({space_ok, rd_empty}), 0);
    step(1, 0, 0, 0, 16'hBAD0);
    chk(overflow == 1'b1, "R3 overflow set", 32'(overflow), 1);
    drain(n);
    chk(n == DEPTH, "R8 all accepted", 32'(n), 32'(DEPTH));
    chk(overflow == 1'b1, "R3 sticky", 32'(overflow), 1);
    do_reset();
    chk(overflow == 1'b0, "R1 reset clears overflow", 32'(overflow), 0);

    // R7: write and pop together in the middle
    fill(3, 16'h8000);
    for (int k = 0; k < 4; k++) step(1, 1, 0, 0, 16'h8100 + DW'(k));
    drain(n);
    chk(n == 3, "R7 occupancy kept", 32'(n), 3);

    // R9: write and pop together when full
    do_reset();
    fill(DEPTH, 16'h9000);
    step(1, 1, 0, 1, 16'hDEAD);
    chk(overflow == 1'b1, "R9 overflow", 32'(overflow), 1);
    drain(n);
    chk(n == DEPTH - 1, "R9 write dropped", 32'(n), 32'(DEPTH - 1));

    // R6: pop on empty has no effect
    do_reset();
    step(0, 1, 0, 0, '0);
    step(1, 0, 1, 1, 16'hA55A);
    chk(rd_data == 16'hA55A && rd_sop && rd_eop, "R6 pop ignored then write", 32'(rd_data), 32'hA55A);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule